// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank Tracker

This block sits behind the sampled control pins of a DDR2 memory device model or monitor. On every rising clock it turns chip select, the three active-low strobes (row strobe, column strobe, write enable), clock enable, the bank bits and the address bus into one registered command code. It also supplies the bank, row and column that belong to that command.

Alongside the decoding it keeps, for each of the eight banks, whether a row is open and which row it is. It tracks the power-down flavour entered when clock enable is sampled low. It raises a sticky flag when the command stream breaks a protocol rule. A read or write reports the row held open in the addressed bank, so an observer sees the full location of each access without keeping its own copy of the bank state.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: With clock enable high and chip select sampled high, the command output is NOP (code 0) one cycle later, whatever the strobes carry, and no bank changes state.
- R2: With chip select low and clock enable high, strobes (row, column, write) 0/1/1 give ACT (1), 1/0/1 give RD (2), 1/0/0 give WR (3), 0/1/0 give PRE (4), 0/0/1 give REF (5), 0/0/0 give MRS (6), and any other pattern gives NOP (0). The code appears on `cmd` the cycle after sampling.
- R3: A legal ACT opens bank `ba`, stores the 14-bit address as its row, and reports `ba` on `cmd_bank` and the address on `cmd_row`.
- R4: RD and WR report the bank, the low 10 address bits on `cmd_col`, and the row stored in that bank on `cmd_row`.
- R5: PRE with address bit 10 low closes only bank `ba`; with bit 10 high it closes every bank.
- R6: MRS reports the bank bits on `cmd_bank`, which select the mode register targeted.
- R7: When clock enable is sampled low from the running state, `pwr_state` becomes 1 (precharge power-down) if no bank is open and 2 (active power-down) if any is open. Commands sampled with clock enable low are decoded as NOP. Clock enable high returns `pwr_state` to 0.
- R8: Clock enable sampled low on any of the 4 edges after a legal RD or WR sets `violation`; a drop on the 5th edge or later does not.
- R9: RD or WR to an idle bank, or ACT to an open bank, sets `violation`; an illegal ACT leaves the stored row unchanged.
- R10: REF while any bank is open sets `violation`.
- R11: Reset gives NOP, all banks closed, `pwr_state` 0 and `violation` 0. Once set, `violation` holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank bits |
| addr | input | 14 | Address bus |
| cmd | output | 3 | Registered command code |
| cmd_bank | output | 3 | Bank of the command |
| cmd_row | output | 14 | Row of ACT, RD or WR |
| cmd_col | output | 10 | Column of RD or WR |
| bank_open | output | 8 | One open flag per bank |
| violation | output | 1 | Sticky protocol-violation flag |
| pwr_state | output | 2 | 0 running, 1 precharge power-down, 2 active power-down |

## Verification
The properties assume the inputs are stable around the rising edge and that reset is held for at least one edge before checking begins. They also assume clock enable is only sampled low while the bench expects the power state to follow, meaning the observer never needs to model a self-refresh exit. The bench drives every input on the falling edge and holds it through the next rising edge. It issues legal sequences in the table walk and keeps each deliberate violation in its own reset-bounded directed test, so the sticky flag never masks a later expectation.

// File: rtl/ddr2_cmd_pkg.sv
// Shared types for the DDR2 command tracker.
// Assumes: command codes are fixed and visible on the top-level port.
package ddr2_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_RUN    = 2'd0,
        PWR_PRE_PD = 2'd1,
        PWR_ACT_PD = 2'd2
    } pwr_e;

endpackage

// File: rtl/ddr2_cmd_decode.sv
// Combinational decode of the sampled control pins into a command code.
// Assumes: inputs are already synchronous to the sampling clock; clock
// enable low or chip select high masks the strobes entirely.
module ddr2_cmd_decode
    import ddr2_cmd_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    logic [2:0] strobes;

    assign strobes = {ras_n, cas_n, we_n};

    // Map the strobe pattern to a command, masking by enable and select.
    always_comb begin
        cmd = CMD_NOP;
        if (cke && !cs_n) begin
            unique case (strobes)
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr2_bank_table.sv
// Per-bank open flag and open-row store, with rule checking of each command
// against the current bank state.
// Assumes: one command per cycle; an illegal activate changes nothing.
module ddr2_bank_table
    import ddr2_cmd_pkg::*;
#(
    parameter int BA_W   = 3,
    parameter int ADDR_W = 14,
    parameter int AP_BIT = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  cmd_e                          cmd,
    input  logic [BA_W-1:0]               ba,
    input  logic [ADDR_W-1:0]             addr,
    output logic [(1<<BA_W)-1:0]          open_flags,
    output logic [ADDR_W-1:0]             sel_row,
    output logic                          rule_break,
    output logic                          access_ok
);

    localparam int NBANK = 1 << BA_W;

    logic [NBANK-1:0][ADDR_W-1:0] rows;
    logic                         sel_open;
    logic                         any_open;
    logic                         is_access;

    assign sel_open  = open_flags[ba];
    assign sel_row   = rows[ba];
    assign any_open  = |open_flags;
    assign is_access = (cmd == CMD_RD) || (cmd == CMD_WR);

    // Flag a command that conflicts with the present bank state.
    always_comb begin
        rule_break = 1'b0;
        if (cmd == CMD_ACT && sel_open)   rule_break = 1'b1;
        if (is_access && !sel_open)       rule_break = 1'b1;
        if (cmd == CMD_REF && any_open)   rule_break = 1'b1;
    end

    assign access_ok = is_access && sel_open;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(b));

        // Open on a legal activate, close on a matching or global precharge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_flags[b] <= 1'b0;
                rows[b]       <= '0;
            end else if (cmd == CMD_ACT && hit && !open_flags[b]) begin
                open_flags[b] <= 1'b1;
                rows[b]       <= addr;
            end else if (cmd == CMD_PRE && (hit || addr[AP_BIT])) begin
                open_flags[b] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ddr2_power_track.sv
// Power-down flavour selection and the access window in which clock enable
// must stay high.
// Assumes: bank state cannot change while clock enable is low, so the
// flavour chosen on entry stays valid until exit.
module ddr2_power_track
    import ddr2_cmd_pkg::*;
#(
    parameter int ACC_WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic any_open,
    input  logic access_ok,
    output pwr_e pwr,
    output logic drop_break
);

    localparam int WIN_W = $clog2(ACC_WIN + 1);

    logic [WIN_W-1:0] win_cnt;

    assign drop_break = !cke && (win_cnt != '0);

    // Reload the window on an access, otherwise count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (access_ok) begin
            win_cnt <= WIN_W'(ACC_WIN);
        end else if (win_cnt != '0) begin
            win_cnt <= win_cnt - 1'b1;
        end
    end

    // Choose the power-down flavour on entry and leave on clock enable high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr <= PWR_RUN;
        end else if (cke) begin
            pwr <= PWR_RUN;
        end else if (pwr == PWR_RUN) begin
            pwr <= any_open ? PWR_ACT_PD : PWR_PRE_PD;
        end
    end

endmodule

// File: rtl/ddr2_cmd_tracker.sv
// Top level: decodes the control pins, tracks bank state and power mode,
// registers the command with its bank/row/column and keeps a sticky
// protocol-violation flag.
// Assumes: all inputs are sampled on the rising clock; reset is synchronous.
module ddr2_cmd_tracker
    import ddr2_cmd_pkg::*;
#(
    parameter int BA_W    = 3,
    parameter int ADDR_W  = 14,
    parameter int COL_W   = 10,
    parameter int AP_BIT  = 10,
    parameter int ACC_WIN = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic [ADDR_W-1:0]      addr,
    output logic [2:0]             cmd,
    output logic [BA_W-1:0]        cmd_bank,
    output logic [ADDR_W-1:0]      cmd_row,
    output logic [COL_W-1:0]       cmd_col,
    output logic [(1<<BA_W)-1:0]   bank_open,
    output logic                   violation,
    output logic [1:0]             pwr_state
);

    localparam int NBANK = 1 << BA_W;

    cmd_e              dec_cmd;
    cmd_e              cmd_q;
    logic [ADDR_W-1:0] sel_row;
    logic              rule_break;
    logic              access_ok;
    logic              drop_break;
    pwr_e              pwr;
    logic [NBANK-1:0]  open_flags;
    logic [BA_W-1:0]   bank_d;
    logic [ADDR_W-1:0] row_d;
    logic [COL_W-1:0]  col_d;

    ddr2_cmd_decode i_decode (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (dec_cmd)
    );

    ddr2_bank_table #(
        .BA_W   (BA_W),
        .ADDR_W (ADDR_W),
        .AP_BIT (AP_BIT)
    ) i_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (dec_cmd),
        .ba         (ba),
        .addr       (addr),
        .open_flags (open_flags),
        .sel_row    (sel_row),
        .rule_break (rule_break),
        .access_ok  (access_ok)
    );

    ddr2_power_track #(
        .ACC_WIN (ACC_WIN)
    ) i_power (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .any_open   (|open_flags),
        .access_ok  (access_ok),
        .pwr        (pwr),
        .drop_break (drop_break)
    );

    // Pick the bank, row and column fields that belong to the command.
    always_comb begin
        bank_d = '0;
        row_d  = '0;
        col_d  = '0;
        unique case (dec_cmd)
            CMD_ACT: begin
                bank_d = ba;
                row_d  = addr;
            end
            CMD_RD, CMD_WR: begin
                bank_d = ba;
                row_d  = sel_row;
                col_d  = addr[COL_W-1:0];
            end
            CMD_PRE, CMD_MRS: bank_d = ba;
            default: ;
        endcase
    end

    // Register the decoded command and its location fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= CMD_NOP;
            cmd_bank <= '0;
            cmd_row  <= '0;
            cmd_col  <= '0;
        end else begin
            cmd_q    <= dec_cmd;
            cmd_bank <= bank_d;
            cmd_row  <= row_d;
            cmd_col  <= col_d;
        end
    end

    // Hold the violation flag once any rule is broken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            violation <= 1'b0;
        end else if (rule_break || drop_break) begin
            violation <= 1'b1;
        end
    end

    assign cmd       = cmd_q;
    assign bank_open = open_flags;
    assign pwr_state = pwr;

endmodule

// File: rtl/ddr2_cmd_tracker_chk.sv
// Protocol properties of the command tracker, attached by bind.
// Assumes: observes only the top-level ports.
module ddr2_cmd_tracker_chk #(
    parameter int BA_W   = 3,
    parameter int ADDR_W = 14,
    parameter int AP_BIT = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cke,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [ADDR_W-1:0]    addr,
    input logic [2:0]           cmd,
    input logic [(1<<BA_W)-1:0] bank_open,
    input logic                 violation,
    input logic [1:0]           pwr_state
);

    // R1
    deselect_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && cs_n) |=> (cmd == 3'd0) && $stable(bank_open));

    // R5
    precharge_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && !ras_n && cas_n && !we_n && addr[AP_BIT])
        |=> (bank_open == '0));

    // R7
    pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (pwr_state != 2'd0) && (cmd == 3'd0));

    // R7
    pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> (pwr_state == 2'd0));

    // R10
    refresh_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && !ras_n && !cas_n && we_n && (bank_open != '0))
        |=> violation);

    // R11
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);

endmodule

bind ddr2_cmd_tracker ddr2_cmd_tracker_chk #(
    .BA_W   (BA_W),
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .cmd       (cmd),
    .bank_open (bank_open),
    .violation (violation),
    .pwr_state (pwr_state)
);

// File: tb/test_ddr2_cmd_tracker.sv
module test_ddr2_cmd_tracker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cke, cs_n, ras_n, cas_n, we_n;
    logic [2:0]  ba;
    logic [13:0] addr;
    logic [2:0]  cmd;
    logic [2:0]  cmd_bank;
    logic [13:0] cmd_row;
    logic [9:0]  cmd_col;
    logic [7:0]  bank_open;
    logic        violation;
    logic [1:0]  pwr_state;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    ddr2_cmd_tracker i_ddr2_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd(cmd),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .bank_open(bank_open), .violation(violation), .pwr_state(pwr_state)
    );

    typedef struct packed {
        logic        cke;
        logic        cs_n;
        logic [2:0]  rcw;
        logic [2:0]  ba;
        logic [13:0] addr;
        logic [2:0]  ecmd;
        logic [2:0]  ebank;
        logic [13:0] erow;
        logic [9:0]  ecol;
        logic [7:0]  eopen;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t TAB [NVEC] = '{
        '{1'b1, 1'b0, 3'b111, 3'd0, 14'h0000, 3'd0, 3'd0, 14'h0000, 10'h000, 8'h00}, // R2 nop
        '{1'b1, 1'b0, 3'b011, 3'd2, 14'h1234, 3'd1, 3'd2, 14'h1234, 10'h000, 8'h04}, // R3 act
        '{1'b1, 1'b1, 3'b011, 3'd3, 14'h0111, 3'd0, 3'd0, 14'h0000, 10'h000, 8'h04}, // R1 deselect
        '{1'b1, 1'b0, 3'b101, 3'd2, 14'h0055, 3'd2, 3'd2, 14'h1234, 10'h055, 8'h04}, // R4 read
        '{1'b1, 1'b0, 3'b100, 3'd2, 14'h03FF, 3'd3, 3'd2, 14'h1234, 10'h3FF, 8'h04}, // R4 write
        '{1'b1, 1'b0, 3'b011, 3'd7, 14'h3FFF, 3'd1, 3'd7, 14'h3FFF, 10'h000, 8'h84}, // R3 act top bank
        '{1'b1, 1'b0, 3'b010, 3'd2, 14'h0000, 3'd4, 3'd2, 14'h0000, 10'h000, 8'h80}, // R5 single pre
        '{1'b1, 1'b0, 3'b000, 3'd1, 14'h0042, 3'd6, 3'd1, 14'h0000, 10'h000, 8'h80}, // R6 mode set
        '{1'b1, 1'b0, 3'b010, 3'd0, 14'h0400, 3'd4, 3'd0, 14'h0000, 10'h000, 8'h00}, // R5 pre all
        '{1'b1, 1'b0, 3'b001, 3'd5, 14'h0000, 3'd5, 3'd0, 14'h0000, 10'h000, 8'h00}, // R2 refresh
        '{1'b1, 1'b0, 3'b011, 3'd0, 14'h0005, 3'd1, 3'd0, 14'h0005, 10'h000, 8'h01}, // R3 act bank0
        '{1'b1, 1'b0, 3'b101, 3'd0, 14'h0407, 3'd2, 3'd0, 14'h0005, 10'h007, 8'h01}, // R4 read
        '{1'b1, 1'b0, 3'b110, 3'd4, 14'h0000, 3'd0, 3'd0, 14'h0000, 10'h000, 8'h01}  // R2 unlisted
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Drive one cycle of pins and wait until the following falling edge.
    task automatic step(input logic c, input logic s, input logic [2:0] rcw,
                        input logic [2:0] b, input logic [13:0] a);
        cke = c; cs_n = s; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nop();
        step(1'b1, 1'b0, 3'b111, 3'd0, 14'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        nop();
        nop();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got hung expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; ba = '0; addr = '0;
        @(negedge clk);
        do_reset();

        // R11 reset state
        check("R11 cmd", 32'(cmd), 0);
        check("R11 open", 32'(bank_open), 0);
        check("R11 violation", 32'(violation), 0);
        check("R11 pwr", 32'(pwr_state), 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            step(TAB[i].cke, TAB[i].cs_n, TAB[i].rcw, TAB[i].ba, TAB[i].addr);
            check("R2 cmd", 32'(cmd), 32'(TAB[i].ecmd));
            check("R3/R6 bank", 32'(cmd_bank), 32'(TAB[i].ebank));
            check("R3/R4 row", 32'(cmd_row), 32'(TAB[i].erow));
            check("R4 col", 32'(cmd_col), 32'(TAB[i].ecol));
            check("R5 open", 32'(bank_open), 32'(TAB[i].eopen));
            check("R9 no violation", 32'(violation), 0);
        end

        // R7 precharge power-down, activate masked
        do_reset();
        step(1'b0, 1'b0, 3'b011, 3'd1, 14'h0010);
        check("R7 pre pd", 32'(pwr_state), 1);
        check("R7 masked cmd", 32'(cmd), 0);
        check("R7 masked open", 32'(bank_open), 0);
        nop();
        check("R7 exit", 32'(pwr_state), 0);

        // R7 active power-down
        step(1'b1, 1'b0, 3'b011, 3'd3, 14'h0020);
        step(1'b0, 1'b1, 3'b111, 3'd0, 14'h0);
        check("R7 act pd", 32'(pwr_state), 2);
        step(1'b0, 1'b1, 3'b111, 3'd0, 14'h0);
        check("R7 act pd hold", 32'(pwr_state), 2);
        nop();
        check("R7 exit act", 32'(pwr_state), 0);
        check("R7 no violation", 32'(violation), 0);

        // R8 drop right after a read
        step(1'b1, 1'b0, 3'b101, 3'd3, 14'h0001);
        step(1'b0, 1'b1, 3'b111, 3'd0, 14'h0);
        check("R8 drop after read", 32'(violation), 1);

        // R8 drop on last edge of window
        do_reset();
        step(1'b1, 1'b0, 3'b011, 3'd4, 14'h0002);
        step(1'b1, 1'b0, 3'b100, 3'd4, 14'h0003);
        repeat (3) nop();
        step(1'b0, 1'b1, 3'b111, 3'd0, 14'h0);
        check("R8 drop edge 4", 32'(violation), 1);

        // R8 drop after window closed
        do_reset();
        step(1'b1, 1'b0, 3'b011, 3'd4, 14'h0002);
        step(1'b1, 1'b0, 3'b100, 3'd4, 14'h0003);
        repeat (4) nop();
        step(1'b0, 1'b1, 3'b111, 3'd0, 14'h0);
        check("R8 drop edge 5 ok", 32'(violation), 0);
        check("R8 act pd", 32'(pwr_state), 2);

        // R9 read to idle bank, sticky
        do_reset();
        step(1'b1, 1'b0, 3'b101, 3'd6, 14'h0000);
        check("R9 read idle", 32'(violation), 1);
        repeat (3) nop();
        check("R11 sticky", 32'(violation), 1);
        do_reset();
        check("R11 cleared", 32'(violation), 0);

        // R9 activate to open bank keeps old row
        step(1'b1, 1'b0, 3'b011, 3'd5, 14'h0ABC);
        check("R9 first act ok", 32'(violation), 0);
        step(1'b1, 1'b0, 3'b011, 3'd5, 14'h1DEF);
        check("R9 double act", 32'(violation), 1);
        step(1'b1, 1'b0, 3'b101, 3'd5, 14'h0000);
        check("R9 row kept", 32'(cmd_row), 32'h0ABC);

        // R10 refresh with open bank
        do_reset();
        step(1'b1, 1'b0, 3'b011, 3'd1, 14'h0007);
        step(1'b1, 1'b0, 3'b001, 3'd0, 14'h0000);
        check("R10 refresh open", 32'(violation), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule